// File: doc/BRIEF.md
# Reorder Buffer with Register Renaming and Precise Recovery

This block is a circular reorder buffer whose entries double as the physical register file, with the rename table and the architectural register file held beside it. The decode stage dispatches one instruction per cycle into the tail entry. The entry's index becomes the physical register number, and the instruction's destination register is renamed to that index. Functional units report completions out of order. Each completion carries a tag, a result value, a fault flag and the branch outcome it resolved. Completed entries leave the head in program order and copy their results into the architectural file.

The block also owns the machine run state, which other stages decode. A branch that completes with a fault moves the machine from running to a fault state. Fetch stops, while older work keeps completing and retiring. When the faulting branch reaches the head, the block enters a flush state. It empties the buffer, points every rename entry back at the architectural file, and presents the branch's PC and its resolved direction for the restart. Once the execution units are drained it reports recovery, and fetch returns it to running. A halt at the head starts the halting sequence. A one-cycle bit vector of the indices retired in each cycle lets the memory queue release its stores.

Top module: `rob_rename`

## Requirements
- R1: After reset the run state is RUNNING (code 1), every rename entry refers to the architectural file (lk_in_arf=1), every architectural value is 0, ret_vec is all zero and disp_ready is 1.
- R2: The buffer is empty when head equals tail and full when tail+1 equals head modulo DEPTH, so at most DEPTH-1 entries are in flight. When full, disp_ready is 0, and a held disp_valid neither advances disp_tag nor allocates an entry.
- R3: A dispatch is accepted only in RUNNING and when the buffer is not full. It takes the entry given by disp_tag, which starts at 0 after reset. The tail then increments modulo DEPTH, and the new entry starts incomplete and fault-free.
- R4: A dispatch with disp_has_dst=1 renames disp_arch to its tag. Lookups of that register then return lk_in_arf=0, lk_tag equal to the tag, and lk_ready=0 until the entry completes.
- R5: A dispatch with disp_has_dst=0 allocates an entry but leaves every rename entry and architectural value unchanged, whatever disp_arch holds.
- R6: A completion marks its entry complete. If the entry has a destination, the completion also stores cmp_value, and a lookup that maps to the entry then returns lk_ready=1 with that value. Completions may arrive in any order, up to NCMP per cycle.
- R7: Retirement happens only in RUNNING or FAULT. It removes complete, non-faulting entries from the head in program order, at most RETW per cycle. For each entry retired at a clock edge, its ret_vec bit is 1 for the following cycle only.
- R8: A retiring entry with a destination copies its value into the architectural register. The rename entry returns to the architectural file only if it still holds that entry's index.
- R9: A completion with cmp_fault=1 in RUNNING flags its entry and moves the state to FAULT (code 2). In FAULT, older entries still complete and retire.
- R10: A flagged entry at the head is not retired. Instead the state goes to FLUSH (code 3), rec_pc takes the entry's PC and rec_taken takes its resolved direction. In FLUSH, head is set to tail, every rename entry returns to the architectural file and dispatch is refused. fu_idle moves the state to RECOVERY (code 4), and resume then moves it to RUNNING.
- R11: A halt entry at the head retires and moves the state to HALTING (code 5), after which nothing retires. stores_drained then moves the state to HALTED (code 6), which holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_arch | input | AW | Destination architectural register |
| disp_pc | input | PCW | Instruction PC |
| disp_halt | input | 1 | Instruction is a halt |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | IW | Entry index given to the dispatch |
| cmp_valid | input | NCMP | Completion strobe per port |
| cmp_tag | input | NCMP*IW | Completing entry per port |
| cmp_value | input | NCMP*DW | Result per port |
| cmp_fault | input | NCMP | Mispredicted-branch flag per port |
| cmp_taken | input | NCMP | Resolved branch direction per port |
| lk_arch | input | NLK*AW | Architectural register per lookup |
| lk_in_arf | output | NLK | Value lives in the architectural file |
| lk_tag | output | NLK*IW | Physical entry when renamed |
| lk_ready | output | NLK | Value available |
| lk_value | output | NLK*DW | Current value |
| fu_idle | input | 1 | Execution units hold no work |
| resume | input | 1 | Fetch has restarted |
| stores_drained | input | 1 | Retired stores are committed |
| run_state | output | 3 | Machine run state |
| rec_pc | output | PCW | Restart PC of the faulting branch |
| rec_taken | output | 1 | Resolved direction of that branch |
| ret_vec | output | DEPTH | Indices retired at the last edge |

## Verification
The checker takes for granted that completion tags name entries that are in flight, that each entry completes at most once, and that fu_idle is raised only after completions for flushed entries have stopped. Under those conditions the pointer, flush and state-sequence properties are meaningful. The directed stimulus keeps to these conditions: it completes only tags it received from disp_tag, each exactly once, and it raises fu_idle and resume only once the preceding state has been observed at the ports.

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int DEPTH = 256,
  parameter int NARCH = 32,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int NCMP  = 2,
  parameter int NLK   = 2,
  parameter int RETW  = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = $clog2(NARCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_valid,
  input  logic                disp_has_dst,
  input  logic [AW-1:0]       disp_arch,
  input  logic [PCW-1:0]      disp_pc,
  input  logic                disp_halt,
  output logic                disp_ready,
  output logic [IW-1:0]       disp_tag,
  input  logic [NCMP-1:0]     cmp_valid,
  input  logic [NCMP*IW-1:0]  cmp_tag,
  input  logic [NCMP*DW-1:0]  cmp_value,
  input  logic [NCMP-1:0]     cmp_fault,
  input  logic [NCMP-1:0]     cmp_taken,
  input  logic [NLK*AW-1:0]   lk_arch,
  output logic [NLK-1:0]      lk_in_arf,
  output logic [NLK*IW-1:0]   lk_tag,
  output logic [NLK-1:0]      lk_ready,
  output logic [NLK*DW-1:0]   lk_value,
  input  logic                fu_idle,
  input  logic                resume,
  input  logic                stores_drained,
  output logic [2:0]          run_state,
  output logic [PCW-1:0]      rec_pc,
  output logic                rec_taken,
  output logic [DEPTH-1:0]    ret_vec
);
  localparam logic [2:0] ST_RUN = 3'd1, ST_FAULT = 3'd2, ST_FLUSH = 3'd3,
                         ST_RECOV = 3'd4, ST_HALTING = 3'd5, ST_HALTED = 3'd6;

  logic [IW-1:0]    head, tail;
  logic [DEPTH-1:0] vld, flt, e_dst, e_halt, e_taken;
  logic [DW-1:0]    prf    [DEPTH];
  logic [AW-1:0]    e_arch [DEPTH];
  logic [PCW-1:0]   e_pc   [DEPTH];
  logic [DW-1:0]    arf    [NARCH];
  logic [NARCH-1:0] rat_arf;
  logic [IW-1:0]    rat_tag [NARCH];

  wire running  = run_state == ST_RUN;
  wire full     = (tail + IW'(1)) == head;
  wire ret_en   = running || run_state == ST_FAULT;
  wire do_disp  = disp_valid && disp_ready;

  assign disp_ready = running && !full;
  assign disp_tag   = tail;

  logic [IW-1:0]   ridx [RETW];
  logic [RETW-1:0] rmask;
  logic            stop, hit_flt, hit_halt, cmp_flt_any;
  logic [IW-1:0]   fidx;

  always_comb begin
    rmask = '0; stop = !ret_en; hit_flt = 1'b0; hit_halt = 1'b0; fidx = head;
    for (int k = 0; k < RETW; k++) begin
      ridx[k] = head + IW'(k);
      if (!stop) begin
        if (ridx[k] == tail || !vld[ridx[k]]) stop = 1'b1;
        else if (flt[ridx[k]]) begin
          hit_flt = 1'b1; fidx = ridx[k]; stop = 1'b1;
        end else begin
          rmask[k] = 1'b1;
          if (e_halt[ridx[k]]) begin hit_halt = 1'b1; stop = 1'b1; end
        end
      end
    end
  end

  always_comb begin
    cmp_flt_any = 1'b0;
    for (int j = 0; j < NCMP; j++) cmp_flt_any |= cmp_valid[j] & cmp_fault[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; vld <= '0; flt <= '0; e_taken <= '0;
      run_state <= ST_RUN; rec_pc <= '0; rec_taken <= 1'b0; ret_vec <= '0;
      rat_arf <= '1;
      for (int a = 0; a < NARCH; a++) begin rat_tag[a] <= '0; arf[a] <= '0; end
    end else begin
      ret_vec <= '0;
      for (int j = 0; j < NCMP; j++) begin
        if (cmp_valid[j]) begin
          vld[cmp_tag[j*IW+:IW]]     <= 1'b1;
          flt[cmp_tag[j*IW+:IW]]     <= cmp_fault[j] && running;
          e_taken[cmp_tag[j*IW+:IW]] <= cmp_taken[j];
        end
      end
      for (int k = 0; k < RETW; k++) begin
        if (rmask[k]) begin
          ret_vec[ridx[k]] <= 1'b1;
          if (e_dst[ridx[k]]) begin
            arf[e_arch[ridx[k]]] <= prf[ridx[k]];
            if (!rat_arf[e_arch[ridx[k]]] && rat_tag[e_arch[ridx[k]]] == ridx[k])
              rat_arf[e_arch[ridx[k]]] <= 1'b1;
          end
        end
      end
      head <= head + IW'($countones(rmask));
      if (do_disp) begin
        vld[tail] <= 1'b0;
        flt[tail] <= 1'b0;
        tail <= tail + IW'(1);
        if (disp_has_dst) begin
          rat_arf[disp_arch] <= 1'b0;
          rat_tag[disp_arch] <= tail;
        end
      end
      case (run_state)
        ST_RUN, ST_FAULT: begin
          if (hit_flt) begin
            run_state <= ST_FLUSH;
            rec_pc    <= e_pc[fidx];
            rec_taken <= e_taken[fidx];
          end else if (hit_halt) run_state <= ST_HALTING;
          else if (running && cmp_flt_any) run_state <= ST_FAULT;
        end
        ST_FLUSH: begin
          head    <= tail;
          rat_arf <= '1;
          if (fu_idle) run_state <= ST_RECOV;
        end
        ST_RECOV:   if (resume) run_state <= ST_RUN;
        ST_HALTING: if (stores_drained) run_state <= ST_HALTED;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NCMP; j++)
      if (cmp_valid[j] && e_dst[cmp_tag[j*IW+:IW]])
        prf[cmp_tag[j*IW+:IW]] <= cmp_value[j*DW+:DW];
    if (do_disp) begin
      e_arch[tail] <= disp_arch;
      e_pc[tail]   <= disp_pc;
      e_dst[tail]  <= disp_has_dst;
      e_halt[tail] <= disp_halt;
    end
  end

  for (genvar l = 0; l < NLK; l++) begin : g_lk
    wire [AW-1:0] la = lk_arch[l*AW+:AW];
    assign lk_in_arf[l]        = rat_arf[la];
    assign lk_tag[l*IW+:IW]    = rat_tag[la];
    assign lk_ready[l]         = rat_arf[la] | vld[rat_tag[la]];
    assign lk_value[l*DW+:DW]  = rat_arf[la] ? arf[la] : prf[rat_tag[la]];
  end
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int DEPTH = 256,
  parameter int RETW  = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [IW-1:0]    head,
  input logic [IW-1:0]    tail,
  input logic [2:0]       run_state,
  input logic             fu_idle,
  input logic             resume,
  input logic [DEPTH-1:0] ret_vec
);
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tail + IW'(1)) == head |-> !disp_ready);                                  // R2
  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && disp_ready) |=> tail == $past(tail));                      // R2
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> tail == $past(tail) + IW'(1));              // R3
  AST_RET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ret_vec) <= RETW);                                              // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 3'd3 |=> head == tail);                                       // R10
  AST_FLUSH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 3'd3 && fu_idle) |=> run_state == 3'd4);                     // R10
  AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 3'd4 && resume) |=> run_state == 3'd1);                      // R10
  AST_HALTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 3'd6 |=> run_state == 3'd6);                                  // R11
endmodule

bind rob_rename rob_rename_chk #(.DEPTH(DEPTH), .RETW(RETW)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .head(head), .tail(tail), .run_state(run_state), .fu_idle(fu_idle),
  .resume(resume), .ret_vec(ret_vec)
);

// File: tb/rob_rename_tb_top.sv
module rob_rename_tb_top;
  localparam int DEPTH = 256, NARCH = 32, DW = 32, PCW = 32, NCMP = 2, NLK = 2;
  localparam int IW = 8, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_has_dst = 0, disp_halt = 0;
  logic [AW-1:0] disp_arch = '0;
  logic [PCW-1:0] disp_pc = '0;
  logic disp_ready;
  logic [IW-1:0] disp_tag;
  logic [NCMP-1:0] cmp_valid = '0, cmp_fault = '0, cmp_taken = '0;
  logic [NCMP*IW-1:0] cmp_tag = '0;
  logic [NCMP*DW-1:0] cmp_value = '0;
  logic [NLK*AW-1:0] lk_arch = '0;
  logic [NLK-1:0] lk_in_arf, lk_ready;
  logic [NLK*IW-1:0] lk_tag;
  logic [NLK*DW-1:0] lk_value;
  logic fu_idle = 0, resume = 0, stores_drained = 0;
  logic [2:0] run_state;
  logic [PCW-1:0] rec_pc;
  logic rec_taken;
  logic [DEPTH-1:0] ret_vec;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_rename dut_i (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(input int a);
    lk_arch[0+:AW] = AW'(a); #1;
  endtask

  task automatic disp(input bit dst, input int a, input int pc, input bit halt, output int tag);
    disp_valid = 1; disp_has_dst = dst; disp_arch = AW'(a); disp_pc = PCW'(pc); disp_halt = halt;
    #0 tag = int'(disp_tag);
    tick();
    disp_valid = 0; disp_halt = 0;
  endtask

  task automatic cmp2(input int t0, input int v0, input bit f0, input bit k0,
                      input bit e1, input int t1, input int v1, input bit f1, input bit k1);
    cmp_valid = {e1, 1'b1}; cmp_tag = {IW'(t1), IW'(t0)}; cmp_value = {DW'(v1), DW'(v0)};
    cmp_fault = {f1, f0}; cmp_taken = {k1, k0};
    tick();
    cmp_valid = '0; cmp_fault = '0;
  endtask

  task automatic t_reset();
    chk("R1", "run_state", run_state, 1);
    chk("R1", "disp_ready", disp_ready, 1);
    chk("R1", "ret_vec", ret_vec, 0);
    chk("R3", "first tag", disp_tag, 0);
    for (int a = 0; a < 4; a++) begin
      look(a);
      chk("R1", "in_arf", lk_in_arf[0], 1);
      chk("R1", "arf value", lk_value[0+:DW], 0);
    end
  endtask

  task automatic t_basic_ooo();
    int t0, t1, t2;
    disp(1, 1, 0, 0, t0); disp(1, 2, 4, 0, t1); disp(1, 1, 8, 0, t2);
    chk("R3", "tags", {t0[7:0], t1[7:0], t2[7:0]}, {8'd0, 8'd1, 8'd2});
    look(1);
    chk("R4", "r1 renamed", {lk_in_arf[0], lk_tag[0+:IW], lk_ready[0]}, {1'b0, 8'd2, 1'b0});
    cmp2(2, 22, 0, 0, 0, 0, 0, 0, 0);
    look(1);
    chk("R6", "r1 ready value", {lk_ready[0], lk_value[0+:DW]}, {1'b1, 32'd22});
    tick();
    chk("R7", "no retire past incomplete head", ret_vec, 0);
    cmp2(1, 11, 0, 0, 1, 0, 10, 0, 0);
    tick();
    chk("R7", "three in order", ret_vec, 256'h7);
    look(2);
    chk("R8", "r2 in arf", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd11});
    look(1);
    chk("R8", "r1 last writer", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd22});
    tick();
    chk("R7", "ret_vec one cycle", ret_vec, 0);
  endtask

  task automatic t_alias_nodst();
    int ta, tb, tc;
    disp(1, 4, 12, 0, ta); disp(1, 4, 16, 0, tb);
    cmp2(ta, 30, 0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R7", "older retires", ret_vec, 256'h1 << ta);
    look(4);
    chk("R8", "alias kept for newer", {lk_in_arf[0], lk_tag[0+:IW]}, {1'b0, IW'(tb)});
    cmp2(tb, 40, 0, 0, 0, 0, 0, 0, 0);
    tick();
    look(4);
    chk("R8", "r4 to arf", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd40});
    disp(0, 4, 20, 0, tc);
    look(4);
    chk("R5", "no-dst keeps alias", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd40});
    cmp2(tc, 999, 0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R5", "no-dst retires", ret_vec, 256'h1 << tc);
    look(4);
    chk("R5", "r4 value untouched", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd40});
  endtask

  task automatic t_width();
    int tg[6];
    for (int i = 0; i < 6; i++) disp(1, 8 + i, 100 + i, 0, tg[i]);
    cmp2(tg[1], 1, 0, 0, 1, tg[2], 2, 0, 0);
    cmp2(tg[3], 3, 0, 0, 1, tg[4], 4, 0, 0);
    cmp2(tg[5], 5, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "waiting on head", ret_vec, 0);
    cmp2(tg[0], 0, 0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R7", "first RETW", ret_vec, 256'hF << tg[0]);
    tick();
    chk("R7", "remaining two", ret_vec, 256'h3 << tg[4]);
  endtask

  task automatic t_full();
    int start, bad, tg;
    start = int'(disp_tag); bad = 0;
    for (int i = 0; i < 255; i++) begin
      if (!disp_ready) bad++;
      disp(1, i % 8, i, 0, tg);
      if (tg != (start + i) % 256) bad++;
    end
    chk("R2", "255 accepted in order", bad, 0);
    chk("R2", "full stalls", disp_ready, 0);
    disp_valid = 1; disp_has_dst = 1; disp_arch = 5'd20;
    tick(); tick();
    disp_valid = 0;
    chk("R2", "tag held while full", disp_tag, IW'(start + 255));
    look(20);
    chk("R2", "held request no rename", lk_in_arf[0], 1);
    for (int i = 0; i < 255; i += 2)
      cmp2((start + i) % 256, 1000 + i, 0, 0, i + 1 < 255, (start + i + 1) % 256, 1001 + i, 0, 0);
    repeat (70) tick();
    chk("R2", "drained ready", disp_ready, 1);
    look(0);
    chk("R8", "r0 final", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd1248});
    look(6);
    chk("R8", "r6 final", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd1254});
  endtask

  task automatic t_fault();
    int tcc, ta, tb, tn;
    disp(1, 3, 100, 0, tcc); disp(0, 0, 104, 0, ta); disp(1, 5, 108, 0, tb);
    cmp2(tb, 55, 0, 0, 1, ta, 0, 1, 1);
    chk("R9", "fault state", run_state, 2);
    tick();
    chk("R9", "blocked head", {run_state, ret_vec}, {3'd2, 256'h0});
    chk("R3", "no dispatch in fault", disp_ready, 0);
    cmp2(tcc, 33, 0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R9", "older retires in fault", ret_vec, 256'h1 << tcc);
    chk("R10", "flush entered", run_state, 3);
    chk("R10", "recovery pc/dir", {rec_pc, rec_taken}, {32'd104, 1'b1});
    chk("R10", "no dispatch in flush", disp_ready, 0);
    tick();
    chk("R10", "flush holds without idle", run_state, 3);
    look(5);
    chk("R10", "r5 back to arf", {lk_in_arf[0], lk_value[0+:DW]}, {1'b1, 32'd1253});
    look(3);
    chk("R8", "r3 retired", lk_value[0+:DW], 33);
    fu_idle = 1; tick(); fu_idle = 0;
    chk("R10", "recovery", {run_state, disp_ready}, {3'd4, 1'b0});
    resume = 1; tick(); resume = 0;
    chk("R10", "running again", {run_state, disp_ready}, {3'd1, 1'b1});
    disp(1, 7, 200, 0, tn);
    chk("R10", "buffer emptied", tn, (tb + 1) % 256);
    cmp2(tn, 7, 0, 0, 0, 0, 0, 0, 0);
    tick();
    chk("R10", "next entry retires", ret_vec, 256'h1 << tn);
  endtask

  task automatic t_halt();
    int th, tr;
    disp(0, 0, 300, 1, th); disp(1, 9, 304, 0, tr);
    cmp2(th, 0, 0, 0, 1, tr, 9, 0, 0);
    tick();
    chk("R11", "halting", run_state, 5);
    chk("R11", "only halt retires", ret_vec, 256'h1 << th);
    tick();
    look(9);
    chk("R11", "no retire while halting", {ret_vec, lk_in_arf[0]}, {256'h0, 1'b0});
    stores_drained = 1; tick(); stores_drained = 0;
    chk("R11", "halted", run_state, 6);
    tick();
    chk("R11", "halted holds", run_state, 6);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_basic_ooo();
    t_alias_nodst();
    t_width();
    t_full();
    t_fault();
    t_halt();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule